// File: doc/BRIEF.md
# Bit Field Extraction Unit

This block pulls a contiguous field out of a 16-bit source word and returns it right-aligned in a 16-bit result. A second 16-bit operand, the control word, selects the field. Its low byte carries a field-length code and a starting bit position. The field is cut short when it would run past the top bit of the source. All result bits above the field are zero.

Together with the result, the unit updates four condition flags: negative, zero, overflow and carry. Extraction sets negative and zero from the result, always clears overflow, and leaves carry untouched. The carry register can be loaded from a separate input, so the surrounding datapath keeps control of it.

Operands are taken when `in_valid` is high. The result, the flags and `out_valid` are registered on the next clock edge.

Top module: `bitfield_extract`

## Requirements
- R1: The length code `w` is `ctl[7:4]` and the start position `o` is `ctl[3:0]`. The field is `w+1` bits long, from 1 to 16 bits. `ctl[15:8]` has no effect on any output.
- R2: Result bits `[w:0]` equal source bits `[o+w:o]`. Every result bit above position `w` is zero. For example, `w=3` with `o=2` puts `src[5:2]` into `result[3:0]`.
- R3: When `o+w > 15`, only source bits `[15:o]` are taken. Every result bit above position `15-o` is zero.
- R4: `flag_n` equals bit 15 of the result produced by the operation.
- R5: `flag_z` is 1 exactly when the whole 16-bit result is zero.
- R6: `flag_v` is 0 after every operation.
- R7: An operation never changes `flag_c`. When `c_load` is high, `flag_c` takes `c_in` on the next edge. Otherwise `flag_c` holds its value.
- R8: When `in_valid` is high at an edge, `result`, `flag_n`, `flag_z`, `flag_v` and `out_valid=1` appear after that edge. When `in_valid` is low at an edge, `out_valid` becomes 0 and `result`, `flag_n` and `flag_z` keep their values.
- R9: A synchronous reset clears `result`, all four flags and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| src | input | 16 | Source word |
| ctl | input | 16 | Control word: `[7:4]` length code, `[3:0]` start position |
| c_load | input | 1 | Load the carry flag from `c_in` |
| c_in | input | 1 | New carry value |
| out_valid | output | 1 | Result and flags updated on the last edge |
| result | output | 16 | Extracted field, right-aligned |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Every result and flag of an operation is due exactly one edge after the edge at which `in_valid` was sampled high. A carry load is also visible one edge later. The bench drives each operation at a falling edge and checks the outputs at the next falling edge, half a period after the capturing rising edge. It never samples at a rising edge. Idle cycles are checked at the same point, for `out_valid` low and for held values.

// File: rtl/bitfield_extract.sv
module bitfield_extract #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] ctl,
  input  logic              c_load,
  input  logic              c_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  localparam int FLD_W = $clog2(DATA_W);
  localparam logic [FLD_W-1:0] TOP = FLD_W'(DATA_W - 1);

  logic [FLD_W-1:0]  len_code, start_pos;
  logic [DATA_W-1:0] shifted, keep_mask, field;
  logic              unused_hi;

  assign len_code  = ctl[2*FLD_W-1:FLD_W];
  assign start_pos = ctl[FLD_W-1:0];
  assign unused_hi = ^ctl[DATA_W-1:2*FLD_W];

  // The right shift fills with zeros, so a field that runs past the top bit is clipped.
  assign shifted   = src >> start_pos;
  assign keep_mask = {DATA_W{1'b1}} >> (TOP - len_code);
  assign field     = shifted & keep_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= field;
        flag_n <= field[DATA_W-1];
        flag_z <= (field == '0);
        flag_v <= 1'b0;
      end
      if (c_load) flag_c <= c_in;
    end
  end
endmodule

module bitfield_extract_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] src,
  input logic [DATA_W-1:0] ctl,
  input logic              c_load,
  input logic              c_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((result >> $past(ctl[7:4])) >> 1) == '0);
  a_r3_clip: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((result >> (4'd15 - $past(ctl[3:0]))) >> 1) == '0);
  a_r4_neg: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> flag_n == result[DATA_W-1]);
  a_r5_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> flag_z == (result == '0));
  a_r6_v_clear: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !flag_v);
  a_r7_c_kept: assert property (@(posedge clk) disable iff (rst)
    !c_load |=> $stable(flag_c));
  a_r7_c_load: assert property (@(posedge clk) disable iff (rst)
    c_load |=> flag_c == $past(c_in));
  a_r8_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result));
  a_r9_reset: assert property (@(posedge clk)
    rst |=> !out_valid && result == '0 && !flag_n && !flag_z && !flag_v && !flag_c);

  logic unused_chk;
  assign unused_chk = ^src;
endmodule

bind bitfield_extract bitfield_extract_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_bitfield_extract.sv
module sim_bitfield_extract;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] src = '0;
  logic [15:0] ctl = '0;
  logic        c_load = 1'b0;
  logic        c_in = 1'b0;
  logic        out_valid, flag_n, flag_z, flag_v, flag_c;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bitfield_extract u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .ctl(ctl),
    .c_load(c_load), .c_in(c_in), .out_valid(out_valid), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  function automatic logic [15:0] model(input logic [15:0] s, input int w, input int o);
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++)
      if (i <= w && o + i <= 15) r[i] = s[o + i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] s, input logic [7:0] hi, input int w,
                        input int o, input logic exp_c);
    logic [15:0] e;
    e = model(s, w, o);
    @(negedge clk);
    in_valid = 1'b1; src = s; ctl = {hi, 4'(w), 4'(o)};
    @(negedge clk);
    in_valid = 1'b0;
    check((w + o > 15) ? "R3 clipped field" : "R2 R1 field", {16'h0, result}, {16'h0, e});
    check("R4 R5 R6 R7 R8 flags", {27'h0, out_valid, flag_n, flag_z, flag_v, flag_c},
          {27'h0, 1'b1, e[15], e == 16'h0, 1'b0, exp_c});
  endtask

  task automatic load_c(input logic v);
    @(negedge clk);
    c_load = 1'b1; c_in = v;
    @(negedge clk);
    c_load = 1'b0;
    check("R7 carry load", {31'h0, flag_c}, {31'h0, v});
  endtask

  initial begin
    logic [15:0] pats [5];
    logic [15:0] last;
    pats[0] = 16'hFFFF; pats[1] = 16'hA5C3; pats[2] = 16'h8001;
    pats[3] = 16'h0000; pats[4] = 16'h7E18;
    repeat (2) @(negedge clk);
    check("R9 reset state", {26'h0, out_valid, result == 16'h0, flag_n, flag_z, flag_v, flag_c},
          {26'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
    rst = 1'b0;

    for (int p = 0; p < 5; p++) begin
      logic cv;
      cv = p[0];
      load_c(cv);
      for (int w = 0; w < 16; w++)
        for (int o = 0; o < 16; o++)
          run_op(pats[p], 8'((w * 37 + o * 11 + p * 53) & 8'hFF), w, o, cv);
    end

    run_op(16'hBEEF, 8'h00, 3, 2, 1'b0);
    // R2 example: w=3, o=2 -> src[5:2] of BEEF = 4'hB
    check("R2 example", {16'h0, result}, 32'h0000_000B);

    // R1: the upper control byte changes nothing
    run_op(16'h1234, 8'hFF, 7, 4, 1'b0);
    last = result;
    run_op(16'h1234, 8'h5A, 7, 4, 1'b0);
    check("R1 upper byte ignored", {16'h0, result}, {16'h0, last});

    // R8: an idle cycle drops out_valid and holds the result and flags
    last = result;
    @(negedge clk);
    src = 16'hFFFF; ctl = 16'h00F0;
    @(negedge clk);
    check("R8 idle hold", {15'h0, out_valid, result}, {15'h0, 1'b0, last});

    // R7: carry survives extractions while set
    load_c(1'b1);
    run_op(16'h0000, 8'h00, 15, 0, 1'b1);
    run_op(16'h8000, 8'h00, 15, 0, 1'b1);

    // R9: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset mid-run", {26'h0, out_valid, result == 16'h0, flag_n, flag_z, flag_v, flag_c},
          {26'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule